// File: doc/BRIEF.md
# Byte Sum and Column Parity Engine

This block walks a run of 16-bit words held in a synchronous word memory and treats their contents as a stream of bytes. Over a programmed number of bytes it forms a 16-bit running sum of the byte values and an 8-bit column parity. Each bit of the parity is the XOR of the same bit across all of the bytes. These two results are the usual check codes attached to a communication frame.

A start pulse captures a base word address, a byte count and a packing mode. In pair mode each word supplies two bytes, the high byte first. In low-byte mode each word supplies only its low byte. The engine issues its own memory reads and takes one byte per clock. When the run ends it updates its two result outputs and pulses done. The results then hold until the next non-empty run completes.

Top module: `bytesum_parity`

## Requirements
- R1: The count gives bytes, not words. In pair mode (mode_i=0) a run of n bytes issues ceil(n/2) reads, one per word, at addresses base, base+1, ... modulo the address range. No two reads of the same run fall on adjacent cycles.
- R2: In pair mode the byte stream takes bits 15:8 of a word first and then bits 7:0 of the same word. Words 6164h, 107Bh, FACBh with n=6 give sum 0315h and parity 005Fh.
- R3: sum_o is the sum of all bytes in the run, each taken as an unsigned value 0..255. The sum is kept modulo 2^16 and no overflow indication of any kind exists.
- R4: Bit k of parity_o[7:0] is 1 exactly when an odd number of the run's bytes have bit k set. parity_o[15:8] is always zero.
- R5: In low-byte mode (mode_i=1) each word supplies only bits 7:0, so n bytes issue n reads at consecutive addresses.
- R6: A start with a byte count of 0 does nothing. busy_o stays low, done_o does not pulse, and sum_o and parity_o keep their values.
- R7: In pair mode with n odd, the last word read supplies only its high byte.
- R8: Reads have one cycle of latency. For a start sampled at clock edge E0 with n>0, done_o is high for exactly one cycle after edge E(n+1). busy_o is high from E0 until that same edge, and it falls as done_o rises.
- R9: A start pulse that arrives while busy_o is high is ignored. The run in progress keeps its base, count and mode.
- R10: Every non-empty run starts from a cleared sum and parity. sum_o and parity_o change only at the edge that raises done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled when idle |
| base_addr_i | input | ADDR_W | First word address of the run |
| byte_cnt_i | input | CNT_W | Number of bytes to process |
| mode_i | input | 1 | 0: two bytes per word, 1: low byte only |
| mem_rd_o | output | 1 | Memory read enable |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_rdata_i | input | 16 | Memory read data, one cycle after the read |
| sum_o | output | 16 | Result: byte sum modulo 2^16 |
| parity_o | output | 16 | Result: column parity in bits 7:0, upper bits zero |
| done_o | output | 1 | One-cycle pulse when results update |
| busy_o | output | 1 | Run in progress |

## Verification
The assertions check on every cycle the properties that hold regardless of data. Reads occur only while busy, and pair-mode reads never fall on adjacent cycles. A lower-byte slot always follows a fresh word. done is a single-cycle pulse that coincides with busy falling. The results move only with done, an empty start leaves the engine idle, and a start during a run leaves the captured run parameters untouched. Only the bench's scenarios can show the arithmetic: the sum and parity values, including the quoted example. The same holds for the byte order within a word, the odd-count tail, wrap of the sum past 16 bits and of addresses past the memory end, the exact done latency, and the address sequence.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int SUM_W  = 16;

    typedef enum logic {
        MODE_PAIR = 1'b0,
        MODE_LOW  = 1'b1
    } pack_mode_e;

    // Describes one byte slot travelling from the read stage to the picker
    typedef struct packed {
        logic       valid;
        logic       fresh;   // slot carries a newly read word
        logic       last;    // final byte of the run
        pack_mode_e mode;
    } byte_tag_t;
endpackage

// File: rtl/bsp_issue.sv
module bsp_issue
    import bsp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              mode_i,
    input  logic              pipe_busy_i,
    output logic              accept_o,
    output logic              active_o,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output byte_tag_t         tag_o
);
    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  idx;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] base;
        pack_mode_e        mode;
    } issue_st_t;

    issue_st_t st_q, st_d;

    logic             last_slot;
    logic             fresh_slot;
    logic [CNT_W-1:0] word_ofs;

    always_comb begin
        st_d       = st_q;
        last_slot  = (st_q.idx == (st_q.cnt - CNT_W'(1)));
        fresh_slot = (st_q.mode == MODE_LOW) || !st_q.idx[0];
        word_ofs   = (st_q.mode == MODE_LOW) ? st_q.idx : (st_q.idx >> 1);
        accept_o   = start_i && !st_q.active && !pipe_busy_i && (count_i != '0);

        if (accept_o) begin
            st_d.active = 1'b1;
            st_d.idx    = '0;
            st_d.cnt    = count_i;
            st_d.base   = base_i;
            st_d.mode   = pack_mode_e'(mode_i);
        end else if (st_q.active) begin
            if (last_slot) begin
                st_d.active = 1'b0;
            end else begin
                st_d.idx = st_q.idx + CNT_W'(1);
            end
        end

        active_o    = st_q.active;
        mem_rd_o    = st_q.active && fresh_slot;
        mem_addr_o  = st_q.base + ADDR_W'(word_ofs);
        tag_o.valid = st_q.active;
        tag_o.fresh = fresh_slot;
        tag_o.last  = last_slot;
        tag_o.mode  = st_q.mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, idx: '0, cnt: '0, base: '0, mode: MODE_PAIR};
        end else begin
            st_q <= st_d;
        end
    end

    // R9: a start that lands during a run leaves the captured run unchanged
    a_r9_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && start_i) |=> ($stable(st_q.cnt) && $stable(st_q.base) && $stable(st_q.mode)));

    // R1: in pair mode a word is read once, so reads never sit on adjacent cycles
    a_r1_pair_reads_apart: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && st_q.mode == MODE_PAIR) |=> !mem_rd_o);
endmodule

// File: rtl/bsp_lane.sv
module bsp_lane
    import bsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  byte_tag_t         tag_i,
    input  logic [WORD_W-1:0] rdata_i,
    output logic              pipe_busy_o,
    output logic              byte_valid_o,
    output logic              byte_last_o,
    output logic [BYTE_W-1:0] byte_o
);
    typedef struct packed {
        byte_tag_t         slot;
        logic [BYTE_W-1:0] hold;   // low byte saved for the next slot
    } lane_st_t;

    lane_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.slot = tag_i;
        if (st_q.slot.valid && st_q.slot.fresh) begin
            st_d.hold = rdata_i[BYTE_W-1:0];
        end

        if (!st_q.slot.fresh) begin
            byte_o = st_q.hold;
        end else if (st_q.slot.mode == MODE_LOW) begin
            byte_o = rdata_i[BYTE_W-1:0];
        end else begin
            byte_o = rdata_i[WORD_W-1 -: BYTE_W];
        end

        byte_valid_o = st_q.slot.valid;
        byte_last_o  = st_q.slot.valid && st_q.slot.last;
        pipe_busy_o  = st_q.slot.valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{slot: '{valid: 1'b0, fresh: 1'b0, last: 1'b0, mode: MODE_PAIR}, hold: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R2: a held low byte is consumed only right after its word arrived
    a_r2_low_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.slot.valid && !st_q.slot.fresh) |-> $past(st_q.slot.valid && st_q.slot.fresh));
endmodule

// File: rtl/bsp_accum.sv
module bsp_accum
    import bsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              byte_valid_i,
    input  logic              byte_last_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [SUM_W-1:0]  sum_o,
    output logic [SUM_W-1:0]  parity_o,
    output logic              done_o
);
    typedef struct packed {
        logic [SUM_W-1:0]  acc_sum;
        logic [BYTE_W-1:0] acc_par;
        logic [SUM_W-1:0]  res_sum;
        logic [BYTE_W-1:0] res_par;
        logic              done;
    } acc_st_t;

    acc_st_t st_q, st_d;

    logic [SUM_W-1:0]  sum_next;
    logic [BYTE_W-1:0] par_next;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        sum_next  = st_q.acc_sum + SUM_W'(byte_i);
        par_next  = st_q.acc_par ^ byte_i;

        if (clear_i) begin
            st_d.acc_sum = '0;
            st_d.acc_par = '0;
        end else if (byte_valid_i) begin
            st_d.acc_sum = sum_next;
            st_d.acc_par = par_next;
            if (byte_last_i) begin
                st_d.res_sum = sum_next;
                st_d.res_par = par_next;
                st_d.done    = 1'b1;
            end
        end

        sum_o    = st_q.res_sum;
        parity_o = {{(SUM_W - BYTE_W){1'b0}}, st_q.res_par};
        done_o   = st_q.done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: done lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R10: results move only together with done
    a_r10_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(st_q.res_sum) || !$stable(st_q.res_par)) |-> st_q.done);
endmodule

// File: rtl/bytesum_parity.sv
module bytesum_parity
    import bsp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [CNT_W-1:0]  byte_cnt_i,
    input  logic              mode_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [15:0]       mem_rdata_i,
    output logic [15:0]       sum_o,
    output logic [15:0]       parity_o,
    output logic              done_o,
    output logic              busy_o
);
    logic              accept;
    logic              issue_active;
    logic              pipe_busy;
    byte_tag_t         tag;
    logic              byte_valid;
    logic              byte_last;
    logic [BYTE_W-1:0] byte_val;

    bsp_issue #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .base_i      (base_addr_i),
        .count_i     (byte_cnt_i),
        .mode_i      (mode_i),
        .pipe_busy_i (pipe_busy),
        .accept_o    (accept),
        .active_o    (issue_active),
        .mem_rd_o    (mem_rd_o),
        .mem_addr_o  (mem_addr_o),
        .tag_o       (tag)
    );

    bsp_lane u_lane (
        .clk          (clk),
        .rst_n        (rst_n),
        .tag_i        (tag),
        .rdata_i      (mem_rdata_i),
        .pipe_busy_o  (pipe_busy),
        .byte_valid_o (byte_valid),
        .byte_last_o  (byte_last),
        .byte_o       (byte_val)
    );

    bsp_accum u_accum (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (accept),
        .byte_valid_i (byte_valid),
        .byte_last_i  (byte_last),
        .byte_i       (byte_val),
        .sum_o        (sum_o),
        .parity_o     (parity_o),
        .done_o       (done_o)
    );

    always_comb begin
        busy_o = issue_active || pipe_busy;
    end

    // R1: reads only happen inside a run
    a_r1_read_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> busy_o);

    // R8: busy falls exactly as done rises, never overlapping
    a_r8_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R6: an empty start leaves the engine idle
    a_r6_empty_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && byte_cnt_i == '0) |=> !busy_o);
endmodule

// File: tb/bytesum_parity_test.sv
`timescale 1ns/1ps
module bytesum_parity_test;
    localparam int ADDR_W = 8;
    localparam int CNT_W  = 10;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] base_addr_i = '0;
    logic [CNT_W-1:0]  byte_cnt_i = '0;
    logic              mode_i = 1'b0;
    logic              mem_rd_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [15:0]       mem_rdata_i = '0;
    logic [15:0]       sum_o;
    logic [15:0]       parity_o;
    logic              done_o;
    logic              busy_o;

    logic [15:0] mem [DEPTH];

    int checks = 0;
    int errors = 0;
    int rd_seen = 0;
    int addr_err = 0;
    logic [ADDR_W-1:0] exp_base = '0;

    always #4 clk = ~clk;

    bytesum_parity #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .base_addr_i (base_addr_i),
        .byte_cnt_i  (byte_cnt_i),
        .mode_i      (mode_i),
        .mem_rd_o    (mem_rd_o),
        .mem_addr_o  (mem_addr_o),
        .mem_rdata_i (mem_rdata_i),
        .sum_o       (sum_o),
        .parity_o    (parity_o),
        .done_o      (done_o),
        .busy_o      (busy_o)
    );

    // Word memory with one cycle read latency, plus address monitor
    always @(posedge clk) begin
        if (mem_rd_o) begin
            mem_rdata_i <= mem[mem_addr_o];
            if (mem_addr_o !== ADDR_W'(exp_base + ADDR_W'(rd_seen))) addr_err++;
            rd_seen++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic model(input logic [ADDR_W-1:0] base, input int n, input bit low,
                         output logic [15:0] s, output logic [7:0] p);
        s = '0;
        p = '0;
        for (int i = 0; i < n; i++) begin
            logic [15:0] w;
            logic [7:0]  b;
            w = mem[ADDR_W'(base + ADDR_W'(low ? i : i / 2))];
            if (low) b = w[7:0];
            else     b = (i % 2 == 0) ? w[15:8] : w[7:0];
            s = s + 16'(b);
            p = p ^ b;
        end
    endtask

    task automatic run_case(input logic [ADDR_W-1:0] base, input int n, input bit low,
                            input bit poke, input string tag);
        logic [15:0] es;
        logic [7:0]  ep;
        logic [15:0] prev_s;
        logic [15:0] prev_p;
        int cyc;
        int words;
        model(base, n, low, es, ep);
        prev_s = sum_o;
        prev_p = parity_o;
        @(negedge clk);
        exp_base    = base;
        rd_seen     = 0;
        addr_err    = 0;
        start_i     = 1'b1;
        base_addr_i = base;
        byte_cnt_i  = CNT_W'(n);
        mode_i      = low;
        @(negedge clk);
        start_i = 1'b0;
        if (n == 0) begin
            // R6: empty run
            chk(busy_o == 1'b0, "R6 busy", busy_o, 0);
            for (int k = 0; k < 4; k++) begin
                chk(done_o == 1'b0, "R6 done", done_o, 0);
                @(negedge clk);
            end
            chk(sum_o == prev_s && parity_o == prev_p, "R6 results", sum_o, prev_s);
            chk(rd_seen == 0, "R6 reads", rd_seen, 0);
            return;
        end
        chk(busy_o == 1'b1, "R8 busy after start", busy_o, 1);
        cyc = 0;
        while (!done_o && cyc < 5000) begin
            if (poke && cyc == 1) begin
                start_i     = 1'b1;
                byte_cnt_i  = CNT_W'(5);
                mode_i      = ~low;
                base_addr_i = base + 8'd7;
            end else begin
                start_i = 1'b0;
            end
            // R10: old results hold during the run
            if (sum_o != prev_s || parity_o != prev_p) begin
                chk(1'b0, "R10 hold during run", sum_o, prev_s);
                prev_s = sum_o;
                prev_p = parity_o;
            end
            @(negedge clk);
            cyc++;
            if (!done_o && !busy_o) chk(1'b0, "R8 busy dropped early", cyc, n + 1);
        end
        start_i = 1'b0;
        words = low ? n : (n + 1) / 2;
        chk(cyc == n + 1, {tag, " R8 latency"}, cyc, n + 1);
        chk(busy_o == 1'b0, "R8 busy at done", busy_o, 0);
        chk(sum_o == es, {tag, " R3 sum"}, sum_o, es);
        chk(parity_o == {8'h00, ep}, {tag, " R4 parity"}, parity_o, {8'h00, ep});
        chk(rd_seen == words, low ? "R5 reads" : "R1 reads", rd_seen, words);
        chk(addr_err == 0, "R1 addresses", addr_err, 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R8 done single", done_o, 0);
        chk(sum_o == es && parity_o == {8'h00, ep}, "R10 results held", sum_o, es);
    endtask

    initial begin
        #(8 * 190000);
        chk(1'b0, "watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 16'(i * 40503 + 12345) ^ 16'(i << 9);
        repeat (3) @(negedge clk);
        chk(sum_o == 16'h0 && parity_o == 16'h0 && !done_o && !busy_o && !mem_rd_o,
            "R8 reset state", {sum_o, parity_o}, 0);
        rst_n = 1'b1;

        // R2: quoted example, high byte first
        mem[16] = 16'h6164; mem[17] = 16'h107B; mem[18] = 16'hFACB;
        run_case(8'd16, 6, 1'b0, 1'b0, "R2");
        chk(sum_o == 16'h0315, "R2 example sum", sum_o, 16'h0315);
        chk(parity_o == 16'h005F, "R2 example parity", parity_o, 16'h005F);

        // R7: odd count takes only high byte of last word (5 bytes)
        run_case(8'd16, 5, 1'b0, 1'b0, "R7");
        chk(sum_o == 16'h0315 - 16'h00CB, "R7 odd tail sum", sum_o, 16'h0315 - 16'h00CB);

        // R5: low byte mode on the same words
        run_case(8'd16, 3, 1'b1, 1'b0, "R5");
        chk(sum_o == 16'h0064 + 16'h007B + 16'h00CB, "R5 low sum", sum_o, 16'h01AA);

        // R6: empty start keeps results
        run_case(8'd40, 0, 1'b0, 1'b0, "R6");
        run_case(8'd40, 0, 1'b1, 1'b0, "R6");

        // R9: start pokes during a run are ignored
        run_case(8'd30, 12, 1'b0, 1'b1, "R9");
        run_case(8'd200, 9, 1'b1, 1'b1, "R9");

        // Sweep: modes, counts, bases including address wrap (R1 R5 R7 R10)
        for (int m = 0; m < 2; m++) begin
            for (int n = 0; n <= 20; n++) begin
                run_case(8'd0,   n, m[0], 1'b0, m ? "R5" : (n % 2 ? "R7" : "R2"));
                run_case(8'd100, n, m[0], 1'b0, m ? "R5" : (n % 2 ? "R7" : "R2"));
                run_case(8'd250, n, m[0], 1'b0, m ? "R5" : (n % 2 ? "R7" : "R2"));
            end
        end

        // R3: sum wraps past 16 bits (600 bytes of FFh)
        for (int i = 0; i < DEPTH; i++) mem[i] = 16'hFFFF;
        run_case(8'd0, 600, 1'b0, 1'b0, "R3");
        chk(sum_o == 16'(600 * 255), "R3 wrap sum", sum_o, 16'(600 * 255));
        chk(parity_o == 16'h0000, "R4 even column count", parity_o, 0);
        run_case(8'd0, 601, 1'b0, 1'b0, "R3");
        chk(parity_o == 16'h00FF, "R4 odd column count", parity_o, 16'h00FF);

        summary();
        $finish;
    end
endmodule